// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller

This block combines two identical 8-input priority interrupt controllers. One acts as the master. The other acts as the slave, and its request output feeds master input 2. Together they serve 16 request lines numbered 0–15. Software reaches them through a synchronous 8-bit register port. Each controller has a command port and a data port. There are also two trigger-mode bytes, and one acknowledge port that hands back the number of the winning request.

Each controller is brought up with a short word sequence. That sequence sets its vector base and its cascade configuration. After that, the controller takes mask writes, specific end-of-interrupt commands and readback selections. Each line can be made edge-triggered or level-sensitive, except lines 0, 1, 2, 8 and 13, which always act on edges. Priority is fixed, from highest to lowest: 0, 1, 8–15, 3–7.

Reading the acknowledge port retires the winning request into service. That request then blocks equal and lower priorities until software writes its end-of-interrupt.

Top module: `dual_pic`

Register addresses on `bus_addr`:

| Address | Write | Read |
|---|---|---|
| 0 | master command | master request or in-service register |
| 1 | master data | master mask |
| 2 | slave command | slave request or in-service register |
| 3 | slave data | slave mask |
| 4 | trigger byte for lines 0–7 | trigger byte for lines 0–7 |
| 5 | trigger byte for lines 8–15 | trigger byte for lines 8–15 |
| 6 | — | acknowledge |
| 7 | — | reads 0 |

## Requirements
- R1: A command-port write with bit 4 set (0x11 in use) starts initialisation. The next three data-port writes to that controller are, in order, the vector base, the cascade word and an option word (the option word is discarded). Every data-port write after that loads the mask, which reads back from the data port.
- R2: The acknowledge port returns the top five bits of the winning controller's vector base above the 3-bit input index. With bases 0x00 (master) and 0x08 (slave), this gives line numbers 0–15. The master's cascade word marks which input comes from the slave (0x04 marks input 2). The slave's cascade word low bits hold its identity (2).
- R3: A mask bit of 1 keeps its line from raising `irq_out`, and the request still shows in the request register. A mask bit of 0 lets the line through.
- R4: On an edge-triggered line (trigger bit 0), a rising edge is latched one clock later. The latched request stays pending after the input falls, until it is acknowledged.
- R5: On a level-sensitive line (trigger bit 1), the request follows the input. It is withdrawn if the input falls before acknowledge, and it is raised again after its EOI if the input is still high.
- R6: Lines 0, 1, 2, 8 and 13 behave as edge-triggered whatever their trigger bits hold.
- R7: Priority is fixed in the order 0, 1, 8, 9, …, 15, 3, 4, …, 7.
- R8: An acknowledge read returns the winning line number and, at the clock edge that ends the read, moves that request into the in-service register (for a slave line, the master's cascade bit is set too). With nothing eligible, the read returns 0xFF and changes no state.
- R9: A set in-service bit blocks requests of equal or lower priority. A command write of 0x60|n clears in-service bit n. A slave line needs 0x60|n to the slave and 0x62 to the master.
- R10: Reset leaves both masks at 0xFF, request and in-service registers clear, `irq_out` low and the request register selected. A command write of 0x0A selects the request register for command-port reads, and 0x0B selects the in-service register.
- R11: Trigger bytes reset to 0x00 and read back exactly as written. `irq_lines[2]` has no effect, because master input 2 is fed only by the slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | Interrupt request inputs, line n on bit n |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only for the acknowledge port) |
| bus_addr | input | 3 | Register address, see the address table above |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as the read strobe |
| irq_out | output | 1 | An eligible unmasked request is pending |

## Verification
Register writes and acknowledge side effects take hold at the rising edge that closes the strobe cycle. Read data and the acknowledge value are combinational in the strobe cycle itself. An edge request reaches `irq_out` one edge after the input rises, through slave and master alike. A level request, a mask change or an EOI shows on `irq_out` with no added register. The bench drives every input at a falling edge and samples one time step later. Each `irq_out` check waits at least one full falling-to-falling interval after the stimulus, so it always lands after the edge that makes the result due.

// File: rtl/pic_pkg.sv
package pic_pkg;

   typedef enum logic [1:0] {
      ST_READY = 2'd0,
      ST_BASE  = 2'd1,
      ST_CASC  = 2'd2,
      ST_OPT   = 2'd3
   } init_st_t;

   localparam logic [4:0] EOI_OP   = 5'b01100;
   localparam logic [7:0] SEL_IRR  = 8'h0A;
   localparam logic [7:0] SEL_ISR  = 8'h0B;
   localparam int         INIT_BIT = 4;

   localparam logic [2:0] ADR_MCMD = 3'd0;
   localparam logic [2:0] ADR_MDAT = 3'd1;
   localparam logic [2:0] ADR_SCMD = 3'd2;
   localparam logic [2:0] ADR_SDAT = 3'd3;
   localparam logic [2:0] ADR_TRLO = 3'd4;
   localparam logic [2:0] ADR_TRHI = 3'd5;
   localparam logic [2:0] ADR_ACK  = 3'd6;

   localparam logic [7:0] NO_WINNER = 8'hFF;

endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
   parameter int W = 8,
   localparam int IDXW = $clog2(W)
) (
   input  logic [W-1:0]    req_i,
   output logic            found_o,
   output logic [IDXW-1:0] idx_o
);

   initial assert (W >= 2) else $error("pic_prio_enc: W must be at least 2");

   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int k = W - 1; k >= 0; k--) begin
         if (req_i[k]) begin
            found_o = 1'b1;
            idx_o   = IDXW'(k);
         end
      end
   end

endmodule

// File: rtl/pic_unit.sv
module pic_unit
   import pic_pkg::*;
#(
   parameter int         W         = 8,
   parameter bit         IS_MASTER = 1'b1,
   parameter logic [7:0] CFG3_RST  = 8'h04,
   localparam int        IDXW      = $clog2(W)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [W-1:0]    req_i,
   input  logic [W-1:0]    level_i,
   input  logic            wr_cmd_i,
   input  logic            wr_data_i,
   input  logic [7:0]      wdata_i,
   input  logic            ack_i,
   input  logic [IDXW-1:0] ack_idx_i,
   output logic            int_o,
   output logic [IDXW-1:0] win_o,
   output logic            cas_hit_o,
   output logic [7:0]      base_o,
   output logic [7:0]      id_o,
   output logic [W-1:0]    isr_o,
   output logic [7:0]      cmd_rd_o,
   output logic [7:0]      mask_rd_o
);

   initial assert (W <= 8 && (1 << IDXW) == W)
      else $error("pic_unit: W must be a power of two no wider than a byte");

   init_st_t        st_q;
   logic [W-1:0]    mask_q, lat_q, prev_q, isr_q;
   logic [W-1:0]    irr, cas, rise, ack_set, eoi_clr, avail, allow, elig;
   logic [7:0]      base_q, cfg3_q;
   logic            sel_isr_q;
   logic            isr_any;
   logic [IDXW-1:0] isr_top;
   logic            is_init, is_eoi;

   assign is_init = wr_cmd_i && wdata_i[INIT_BIT];
   assign is_eoi  = wr_cmd_i && (wdata_i[7:3] == EOI_OP);

   generate
      if (IS_MASTER) begin : g_cascade
         assign cas = cfg3_q[W-1:0];
      end else begin : g_leaf
         assign cas = '0;
      end
   endgenerate

   assign rise    = req_i & ~prev_q;
   assign ack_set = ack_i  ? (W'(1) << ack_idx_i) : '0;
   assign eoi_clr = is_eoi ? (W'(1) << wdata_i[IDXW-1:0]) : '0;

   always_comb begin
      for (int k = 0; k < W; k++) begin
         irr[k] = (cas[k] || level_i[k]) ? req_i[k] : lat_q[k];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         lat_q  <= '0;
         isr_q  <= '0;
      end else begin
         prev_q <= req_i;
         lat_q  <= (lat_q & ~ack_set) | (rise & ~level_i & ~cas);
         isr_q  <= is_init ? '0 : ((isr_q & ~eoi_clr) | ack_set);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_READY;
         mask_q    <= '1;
         base_q    <= '0;
         cfg3_q    <= CFG3_RST;
         sel_isr_q <= 1'b0;
      end else begin
         if (is_init) begin
            st_q      <= ST_BASE;
            sel_isr_q <= 1'b0;
         end else if (wr_cmd_i && wdata_i == SEL_IRR) begin
            sel_isr_q <= 1'b0;
         end else if (wr_cmd_i && wdata_i == SEL_ISR) begin
            sel_isr_q <= 1'b1;
         end
         if (wr_data_i) begin
            unique case (st_q)
               ST_BASE: begin
                  base_q <= wdata_i;
                  st_q   <= ST_CASC;
               end
               ST_CASC: begin
                  cfg3_q <= wdata_i;
                  st_q   <= ST_OPT;
               end
               ST_OPT:   st_q   <= ST_READY;
               ST_READY: mask_q <= wdata_i[W-1:0];
            endcase
         end
      end
   end

   pic_prio_enc #(.W(W)) u_isr_pick (
      .req_i   (isr_q),
      .found_o (isr_any),
      .idx_o   (isr_top)
   );

   always_comb begin
      for (int k = 0; k < W; k++) begin
         allow[k] = !isr_any || (k < int'(isr_top));
      end
   end

   assign avail = irr & ~mask_q;
   assign elig  = avail & allow;

   pic_prio_enc #(.W(W)) u_win_pick (
      .req_i   (elig),
      .found_o (int_o),
      .idx_o   (win_o)
   );

   assign cas_hit_o = cas[win_o];
   assign base_o    = base_q;
   assign id_o      = cfg3_q;
   assign isr_o     = isr_q;

   always_comb begin
      cmd_rd_o           = '0;
      mask_rd_o          = '0;
      cmd_rd_o[W-1:0]    = sel_isr_q ? isr_q : irr;
      mask_rd_o[W-1:0]   = mask_q;
   end

   assert_init_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data_i && !wr_cmd_i && st_q == ST_OPT) |=> st_q == ST_READY);

   assert_grant_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int_o |-> (irr[win_o] && !mask_q[win_o]));

   assert_ack_in_service_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !wr_cmd_i) |=> isr_q[$past(ack_idx_i)]);

   assert_eoi_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (is_eoi && !ack_i) |=> !isr_q[$past(wdata_i[IDXW-1:0])]);

endmodule

// File: rtl/dual_pic.sv
module dual_pic
   import pic_pkg::*;
#(
   parameter int           LINES      = 16,
   parameter int           AW         = 3,
   parameter int           CASC_IN    = 2,
   parameter logic [15:0]  FORCE_EDGE = 16'h2107
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] irq_lines,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [AW-1:0]    bus_addr,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   output logic             irq_out
);

   localparam int W    = LINES / 2;
   localparam int IDXW = $clog2(W);

   initial assert (LINES == 16 && AW >= 3 && CASC_IN < W)
      else $error("dual_pic: unsupported parameter set");

   logic [LINES-1:0] trig_q, level_eff;
   logic [W-1:0]     m_req;
   logic             m_int, s_int, m_cas_hit, route, ack_rd;
   logic [IDXW-1:0]  m_win, s_win;
   logic [7:0]       m_base, s_base, s_id, m_cmd_rd, s_cmd_rd, m_mask_rd, s_mask_rd;
   logic [7:0]       ack_val;
   logic [W-1:0]     m_isr;
   logic [7:0]       unused_m_id;
   logic [W-1:0]     unused_s_isr;
   logic             unused_s_cas;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trig_q <= '0;
      end else if (bus_wr && bus_addr == AW'(ADR_TRLO)) begin
         trig_q[W-1:0] <= bus_wdata[W-1:0];
      end else if (bus_wr && bus_addr == AW'(ADR_TRHI)) begin
         trig_q[LINES-1:W] <= bus_wdata[W-1:0];
      end
   end

   assign level_eff = trig_q & ~FORCE_EDGE[LINES-1:0];

   always_comb begin
      m_req          = irq_lines[W-1:0];
      m_req[CASC_IN] = s_int;
   end

   assign ack_rd = bus_rd && bus_addr == AW'(ADR_ACK);
   assign route  = m_int && m_cas_hit && (m_win == s_id[IDXW-1:0]);

   pic_unit #(.W(W), .IS_MASTER(1'b1), .CFG3_RST(8'(1 << CASC_IN))) u_master (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (m_req),
      .level_i   (level_eff[W-1:0]),
      .wr_cmd_i  (bus_wr && bus_addr == AW'(ADR_MCMD)),
      .wr_data_i (bus_wr && bus_addr == AW'(ADR_MDAT)),
      .wdata_i   (bus_wdata),
      .ack_i     (ack_rd && m_int),
      .ack_idx_i (m_win),
      .int_o     (m_int),
      .win_o     (m_win),
      .cas_hit_o (m_cas_hit),
      .base_o    (m_base),
      .id_o      (unused_m_id),
      .isr_o     (m_isr),
      .cmd_rd_o  (m_cmd_rd),
      .mask_rd_o (m_mask_rd)
   );

   pic_unit #(.W(W), .IS_MASTER(1'b0), .CFG3_RST(8'(CASC_IN))) u_slave (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (irq_lines[LINES-1:W]),
      .level_i   (level_eff[LINES-1:W]),
      .wr_cmd_i  (bus_wr && bus_addr == AW'(ADR_SCMD)),
      .wr_data_i (bus_wr && bus_addr == AW'(ADR_SDAT)),
      .wdata_i   (bus_wdata),
      .ack_i     (ack_rd && route),
      .ack_idx_i (s_win),
      .int_o     (s_int),
      .win_o     (s_win),
      .cas_hit_o (unused_s_cas),
      .base_o    (s_base),
      .id_o      (s_id),
      .isr_o     (unused_s_isr),
      .cmd_rd_o  (s_cmd_rd),
      .mask_rd_o (s_mask_rd)
   );

   always_comb begin
      if (!m_int)     ack_val = NO_WINNER;
      else if (route) ack_val = {s_base[7:IDXW], s_win};
      else            ack_val = {m_base[7:IDXW], m_win};
   end

   always_comb begin
      if      (bus_addr == AW'(ADR_MCMD)) bus_rdata = m_cmd_rd;
      else if (bus_addr == AW'(ADR_MDAT)) bus_rdata = m_mask_rd;
      else if (bus_addr == AW'(ADR_SCMD)) bus_rdata = s_cmd_rd;
      else if (bus_addr == AW'(ADR_SDAT)) bus_rdata = s_mask_rd;
      else if (bus_addr == AW'(ADR_TRLO)) bus_rdata = trig_q[W-1:0];
      else if (bus_addr == AW'(ADR_TRHI)) bus_rdata = trig_q[LINES-1:W];
      else if (bus_addr == AW'(ADR_ACK))  bus_rdata = ack_val;
      else                                bus_rdata = '0;
   end

   assign irq_out = m_int;

   assert_empty_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && !m_int && !bus_wr) |=> $stable(m_isr));

   assert_slave_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && route) |-> s_int);

endmodule

// File: tb/dual_pic_tb.sv
module dual_pic_tb;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_lines = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        irq_out;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #(CLK_P / 2) clk = ~clk;

   dual_pic u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_lines (irq_lines),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic chk_irq(input string tag, input logic exp);
      @(negedge clk);
      #1 chk(tag, {7'd0, irq_out}, {7'd0, exp});
   endtask

   task automatic chk_rd(input string tag, input logic [2:0] a, input logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   task automatic set_line(input int n, input logic v);
      @(negedge clk);
      irq_lines[n] = v;
   endtask

   task automatic pulse_line(input int n);
      set_line(n, 1'b1);
      set_line(n, 1'b0);
   endtask

   task automatic t_reset;
      chk_irq("R10 irq after reset", 1'b0);
      chk_rd("R10 master mask reset", 3'd1, 8'hFF);
      chk_rd("R10 slave mask reset", 3'd3, 8'hFF);
      chk_rd("R10 master irr reset", 3'd0, 8'h00);
      chk_rd("R11 trigger low reset", 3'd4, 8'h00);
      chk_rd("R11 trigger high reset", 3'd5, 8'h00);
   endtask

   task automatic t_init;
      wr(3'd0, 8'h11); wr(3'd1, 8'h00); wr(3'd1, 8'h04); wr(3'd1, 8'h01);
      wr(3'd2, 8'h11); wr(3'd3, 8'h08); wr(3'd3, 8'h02); wr(3'd3, 8'h01);
      wr(3'd1, 8'hFF); wr(3'd3, 8'hFF);
      chk_rd("R1 master mask after init", 3'd1, 8'hFF);
      wr(3'd1, 8'hFB);
      chk_rd("R1 master mask cascade open", 3'd1, 8'hFB);
      wr(3'd3, 8'h5A);
      chk_rd("R1 slave mask load", 3'd3, 8'h5A);
      wr(3'd1, 8'h00); wr(3'd3, 8'h00);
   endtask

   task automatic t_mask;
      wr(3'd1, 8'h08);
      pulse_line(3);
      chk_irq("R3 masked line quiet", 1'b0);
      wr(3'd0, 8'h0A);
      chk_rd("R10 irr shows masked request", 3'd0, 8'h08);
      wr(3'd1, 8'h00);
      chk_irq("R3 unmasked line raises", 1'b1);
      chk_rd("R2 ack master line 3", 3'd6, 8'h03);
      wr(3'd0, 8'h0B);
      chk_rd("R10 isr readback", 3'd0, 8'h08);
      wr(3'd0, 8'h63);
      chk_rd("R9 eoi clears isr", 3'd0, 8'h00);
      wr(3'd0, 8'h0A);
   endtask

   task automatic t_edge;
      pulse_line(5);
      chk_irq("R4 edge held after fall", 1'b1);
      chk_rd("R4 ack line 5", 3'd6, 8'h05);
      chk_irq("R4 request retired", 1'b0);
      chk_rd("R4 irr cleared by ack", 3'd0, 8'h00);
      wr(3'd0, 8'h65);
   endtask

   task automatic t_level;
      wr(3'd5, 8'h04);
      set_line(10, 1'b1);
      chk_irq("R5 level raises", 1'b1);
      set_line(10, 1'b0);
      chk_irq("R5 level withdrawn", 1'b0);
      chk_rd("R5 slave irr empty", 3'd2, 8'h00);
      set_line(10, 1'b1);
      chk_rd("R2 ack slave line 10", 3'd6, 8'h0A);
      chk_irq("R9 in service blocks", 1'b0);
      wr(3'd2, 8'h62); wr(3'd0, 8'h62);
      chk_irq("R5 level re-requests after eoi", 1'b1);
      set_line(10, 1'b0);
      chk_irq("R5 level dropped again", 1'b0);
      wr(3'd5, 8'h00);
   endtask

   task automatic t_forced;
      wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
      chk_rd("R11 trigger low readback", 3'd4, 8'hFF);
      chk_rd("R11 trigger high readback", 3'd5, 8'hFF);
      pulse_line(0);
      chk_irq("R6 line 0 stays edge", 1'b1);
      chk_rd("R6 ack line 0", 3'd6, 8'h00);
      wr(3'd0, 8'h60);
      pulse_line(13);
      chk_irq("R6 line 13 stays edge", 1'b1);
      chk_rd("R6 ack line 13", 3'd6, 8'h0D);
      wr(3'd2, 8'h65); wr(3'd0, 8'h62);
      pulse_line(6);
      chk_irq("R5 level line 6 pulse lost", 1'b0);
      wr(3'd4, 8'h00); wr(3'd5, 8'h00);
   endtask

   task automatic t_pin2;
      set_line(2, 1'b1);
      chk_irq("R11 pin 2 ignored", 1'b0);
      chk_rd("R11 master irr with pin 2", 3'd0, 8'h00);
      set_line(2, 1'b0);
   endtask

   task automatic t_priority;
      @(negedge clk);
      irq_lines[3] = 1'b1; irq_lines[9] = 1'b1; irq_lines[1] = 1'b1;
      @(negedge clk);
      irq_lines[3] = 1'b0; irq_lines[9] = 1'b0; irq_lines[1] = 1'b0;
      chk_rd("R7 line 1 wins", 3'd6, 8'h01);
      chk_irq("R9 isr 1 blocks lower", 1'b0);
      wr(3'd0, 8'h61);
      chk_irq("R9 eoi releases", 1'b1);
      chk_rd("R7 line 9 before 3", 3'd6, 8'h09);
      wr(3'd2, 8'h0B); wr(3'd0, 8'h0B);
      chk_rd("R8 slave isr bit 1", 3'd2, 8'h02);
      chk_rd("R8 master cascade bit", 3'd0, 8'h04);
      wr(3'd2, 8'h61);
      chk_irq("R9 cascade bit still blocks", 1'b0);
      wr(3'd0, 8'h62);
      chk_irq("R9 master eoi releases", 1'b1);
      chk_rd("R7 line 3 last", 3'd6, 8'h03);
      wr(3'd0, 8'h63);
      @(negedge clk);
      irq_lines[15] = 1'b1; irq_lines[4] = 1'b1;
      @(negedge clk);
      irq_lines[15] = 1'b0; irq_lines[4] = 1'b0;
      chk_rd("R7 line 15 over 4", 3'd6, 8'h0F);
      wr(3'd2, 8'h67); wr(3'd0, 8'h62);
      chk_rd("R7 then line 4", 3'd6, 8'h04);
      wr(3'd0, 8'h64);
      wr(3'd2, 8'h0A); wr(3'd0, 8'h0A);
   endtask

   task automatic t_empty_ack;
      chk_rd("R8 empty ack", 3'd6, 8'hFF);
      wr(3'd0, 8'h0B);
      chk_rd("R8 empty ack leaves isr", 3'd0, 8'h00);
      wr(3'd0, 8'h0A);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_init;
      t_mask;
      t_edge;
      t_level;
      t_forced;
      t_pin2;
      t_priority;
      t_empty_ack;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule